// File: doc/BRIEF.md
# Timer Interrupt Flag and Enable Controller

This block collects event pulses from a small microcontroller's timers and turns them into interrupt requests. It holds one sticky flag per source (counter overflow, compare match A, compare match B and input capture) and one enable bit per source. Each flag is set by a single-cycle pulse from its timer. The overflow pulse only counts when an external strobe says that the current waveform mode produces overflows.

A flag can be cleared in two independent ways. Software can write a one to the flag's position in the flag register. The interrupt logic can also send an acknowledge strobe naming the vector it is servicing. A source requests an interrupt only while the global interrupt-enable input, its enable bit and its flag are all one. When several sources request at once, the block reports the index of the lowest-numbered one as the vector.

Software reaches both registers through a plain register bus with a one-bit address. Reads are combinational and have no side effects.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every flag and enable bit is zero, both registers read zero and no request is active.
- R2: A one-cycle pulse on `evt_i[k]` sets flag k at the next clock edge. The bit positions are: 0 overflow, 1 compare A, 2 compare B, 3 capture.
- R3: The overflow pulse `evt_i[0]` sets flag 0 only when `ovf_qual_i` is high in the same cycle.
- R4: `irq_req_o[k]` is high exactly when `gie_i`, enable bit k and flag k are all one.
- R5: Writing the flag register (address 0) clears each flag whose `reg_wdata_i` bit is one. Bits written as zero keep their value.
- R6: A cycle with `ack_i` high clears only the flag numbered `ack_vec_i`. The other flags are unchanged.
- R7: If a set pulse and a clear (written one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R8: `irq_any_o` is high when any request is active, and `irq_vec_o` then holds the lowest index k with `irq_req_o[k]` high.
- R9: The enable register (address 1) is plain read/write. Writing it never changes any flag, so a flag that is already pending raises its request in the cycle after it is enabled.
- R10: Bits 7..4 of both registers always read zero, and writes to those bits have no effect.
- R11: While `reg_rd_i` is high, `reg_rdata_o` shows the addressed register in the same cycle. While `reg_rd_i` is low it reads zero. A read never changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gie_i | input | 1 | Global interrupt enable |
| evt_i | input | 4 | One-cycle event pulses, one per source |
| ovf_qual_i | input | 1 | Mode strobe that lets the overflow pulse through |
| ack_i | input | 1 | Vector-serviced strobe |
| ack_vec_i | input | 2 | Index of the vector being serviced |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | Register select: 0 flags, 1 enables |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| irq_req_o | output | 4 | Per-source interrupt requests |
| irq_any_o | output | 1 | Any request is active |
| irq_vec_o | output | 2 | Index of the lowest active request |

## Verification
The hardest case to reach from the ports is a set pulse colliding with a clear on the same flag in the same cycle. It only happens when the event, the write-one or acknowledge, and the flag's current value all line up in one clock. The stimulus reaches it by driving the event together with a write-one to that bit, and separately together with an acknowledge naming that vector. A pseudo-random phase then drives all inputs at once so collisions recur under many enable and priority states. Every cycle is compared against a behavioural model, and the flag register is read back to expose bits that did not clear.

// File: rtl/tic_pkg.sv
// Package: shared register map constants and source numbering for the
// timer interrupt controller. Assumes a one-bit register address.
package tic_pkg;
    localparam int unsigned TIC_DATA_W = 8;

    typedef enum logic {
        TIC_REG_FLAG = 1'b0,
        TIC_REG_EN   = 1'b1
    } tic_reg_e;

    localparam int unsigned TIC_SRC_OVF  = 0;
    localparam int unsigned TIC_SRC_CMPA = 1;
    localparam int unsigned TIC_SRC_CMPB = 2;
    localparam int unsigned TIC_SRC_CAP  = 3;
endpackage

// File: rtl/tic_flag_bank.sv
// Module: tic_flag_bank
// Holds one sticky flag per source. Each flag is set by its event pulse and
// cleared by a write-one mask or by an acknowledge naming its index. A set
// in the same cycle as a clear takes priority. The source at OVF_IDX is also
// gated by a mode qualifier. Assumes the clear mask is already decoded.
module tic_flag_bank #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned VEC_W   = 2,
    parameter int unsigned OVF_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               ovf_qual_i,
    input  logic [NUM_SRC-1:0] clr_mask_i,
    input  logic               ack_i,
    input  logic [VEC_W-1:0]   ack_vec_i,
    output logic [NUM_SRC-1:0] flags_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        logic set_b;
        logic clr_b;
        logic flag_q;

        // Qualify the event: only the overflow source needs the mode strobe.
        if (k == OVF_IDX) begin : g_qual
            assign set_b = evt_i[k] & ovf_qual_i;
        end else begin : g_plain
            assign set_b = evt_i[k];
        end

        // Either clear path may drop the flag.
        assign clr_b = clr_mask_i[k] | (ack_i & (ack_vec_i == VEC_W'(k)));

        // Flag storage: reset, then set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_b) begin
                flag_q <= 1'b1;
            end else if (clr_b) begin
                flag_q <= 1'b0;
            end
        end

        assign flags_o[k] = flag_q;
    end
endmodule

// File: rtl/tic_enable_reg.sv
// Module: tic_enable_reg
// Plain read/write enable bits, one per source. Assumes the write strobe is
// already decoded for this register's address.
module tic_enable_reg #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_q;

    // Enable storage: loads on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q <= wdata_i;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/tic_prio_enc.sv
// Module: tic_prio_enc
// Finds the lowest-numbered active request and flags whether any is active.
// Assumes VEC_W is wide enough to index NUM_SRC.
module tic_prio_enc #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned VEC_W   = 2
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [VEC_W-1:0]   vec_o
);
    // Scan from the top down so the lowest index is written last and wins.
    always_comb begin
        vec_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vec_o = VEC_W'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Module: tmr_irq_ctrl (top)
// Timer interrupt flag/enable controller. It decodes register bus accesses,
// holds the flags and enables, gates the requests with the global enable and
// picks the lowest active vector. Assumes NUM_SRC <= DATA_W. Bits at and
// above NUM_SRC are reserved: they read zero and ignore writes.
module tmr_irq_ctrl
    import tic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = TIC_DATA_W,
    parameter int unsigned OVF_IDX = TIC_SRC_OVF,
    localparam int unsigned VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               ovf_qual_i,
    input  logic               ack_i,
    input  logic [VEC_W-1:0]   ack_vec_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic               reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic [NUM_SRC-1:0] irq_req_o,
    output logic               irq_any_o,
    output logic [VEC_W-1:0]   irq_vec_o
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] clr_mask;
    logic               wr_flag;
    logic               wr_en;
    logic               unused_wdata_hi;

    // Address decode for the two registers.
    assign wr_flag  = reg_wr_i & (tic_reg_e'(reg_addr_i) == TIC_REG_FLAG);
    assign wr_en    = reg_wr_i & (tic_reg_e'(reg_addr_i) == TIC_REG_EN);
    assign clr_mask = wr_flag ? reg_wdata_i[NUM_SRC-1:0] : '0;

    if (DATA_W > NUM_SRC) begin : g_resv
        assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_SRC];
    end else begin : g_nores
        assign unused_wdata_hi = 1'b0;
    end

    tic_flag_bank #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W),
        .OVF_IDX (OVF_IDX)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .ovf_qual_i (ovf_qual_i),
        .clr_mask_i (clr_mask),
        .ack_i      (ack_i),
        .ack_vec_i  (ack_vec_i),
        .flags_o    (flags)
    );

    tic_enable_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
        .en_o    (en)
    );

    // Request gating: global enable, per-source enable and flag.
    assign irq_req_o = flags & en & {NUM_SRC{gie_i}};

    tic_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_prio (
        .req_i (irq_req_o),
        .any_o (irq_any_o),
        .vec_o (irq_vec_o)
    );

    // Combinational read mux; reserved bits stay zero.
    always_comb begin
        reg_rdata_o = '0;
        if (reg_rd_i) begin
            if (tic_reg_e'(reg_addr_i) == TIC_REG_EN) begin
                reg_rdata_o[NUM_SRC-1:0] = en;
            end else begin
                reg_rdata_o[NUM_SRC-1:0] = flags;
            end
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
// Module: tmr_irq_ctrl_chk
// Property checker bound to tmr_irq_ctrl. It watches the ports and the
// internal flag and enable state.
module tmr_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned VEC_W   = 2,
    parameter int unsigned OVF_IDX = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gie_i,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               ovf_qual_i,
    input logic               ack_i,
    input logic               reg_wr_i,
    input logic               reg_addr_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic [NUM_SRC-1:0] irq_req_o,
    input logic               irq_any_o,
    input logic [VEC_W-1:0]   irq_vec_o,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] en
);
    logic [NUM_SRC-1:0] set_eff;
    logic [NUM_SRC-1:0] lower_mask;

    // Effective set pulses as seen at the ports.
    always_comb begin
        set_eff = evt_i;
        set_eff[OVF_IDX] = evt_i[OVF_IDX] & ovf_qual_i;
    end

    // Mask of the request bits below the reported vector.
    assign lower_mask = (NUM_SRC'(1) << irq_vec_o) - NUM_SRC'(1);

    // R7 / R2: every effective set leaves its flag high, whatever clears arrive.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_eff != '0) |=> ((flags & $past(set_eff)) == $past(set_eff)));

    // R4: no request without the global enable or the source's enable.
    p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!gie_i) |-> (irq_req_o == '0)) and ((irq_req_o & ~en) == '0));

    // R8: the vector names an active request with none below it.
    p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o |-> (irq_req_o[irq_vec_o] && ((irq_req_o & lower_mask) == '0)));

    // R9: an enable write with no flag activity leaves the flags alone.
    p_en_write_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i && !ack_i && set_eff == '0) |=> $stable(flags));

    // R10: the reserved read bits are always zero.
    p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[DATA_W-1:NUM_SRC] == '0);

    // R6: an acknowledge never sets a flag that was clear without an event.
    p_ack_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && set_eff == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .VEC_W   (VEC_W),
    .OVF_IDX (OVF_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie_i       (gie_i),
    .evt_i       (evt_i),
    .ovf_qual_i  (ovf_qual_i),
    .ack_i       (ack_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_req_o   (irq_req_o),
    .irq_any_o   (irq_any_o),
    .irq_vec_o   (irq_vec_o),
    .flags       (flags),
    .en          (en)
);

// File: tb/tmr_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed and pseudo-random stimulus against a behavioural model,
// compared every cycle.
module tmr_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie_i = 1'b0;
    logic [3:0] evt_i = '0;
    logic       ovf_qual_i = 1'b0;
    logic       ack_i = 1'b0;
    logic [1:0] ack_vec_i = '0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic       reg_addr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [3:0] irq_req_o;
    logic       irq_any_o;
    logic [1:0] irq_vec_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  m_flag [4];
    bit  m_en   [4];

    always #2 clk = ~clk;

    tmr_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .evt_i(evt_i),
        .ovf_qual_i(ovf_qual_i), .ack_i(ack_i), .ack_vec_i(ack_vec_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_req_o(irq_req_o), .irq_any_o(irq_any_o), .irq_vec_o(irq_vec_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, compare outputs, then advance the model.
    task automatic step(input string tag, input bit g, input bit [3:0] ev,
                        input bit q, input bit ak, input bit [1:0] av,
                        input bit wr, input bit rd, input bit ad,
                        input bit [7:0] wd);
        int e_req, e_rd, e_vec;
        bit e_any;
        gie_i = g; evt_i = ev; ovf_qual_i = q; ack_i = ak; ack_vec_i = av;
        reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = ad; reg_wdata_i = wd;
        #1;
        e_req = 0; e_rd = 0; e_vec = 0; e_any = 0;
        for (int k = 3; k >= 0; k--) begin
            if (g && m_en[k] && m_flag[k]) begin
                e_req |= (1 << k); e_vec = k; e_any = 1;
            end
            if (rd) e_rd |= ((ad ? int'(m_en[k]) : int'(m_flag[k])) << k);
        end
        chk({tag, " R11 rdata"}, int'(reg_rdata_o), e_rd);
        chk({tag, " R4 req"}, int'(irq_req_o), e_req);
        chk({tag, " R8 any"}, int'(irq_any_o), int'(e_any));
        if (e_any) chk({tag, " R8 vec"}, int'(irq_vec_o), e_vec);
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            bit s, c;
            s = ev[k] && (k != 0 || q);
            c = (wr && !ad && wd[k]) || (ak && av == 2'(k));
            if (s) m_flag[k] = 1;
            else if (c) m_flag[k] = 0;
            if (wr && ad) m_en[k] = wd[k];
        end
        @(negedge clk);
    endtask

    task automatic rd_flag(input string tag);
        step(tag, gie_i, 4'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 4; k++) begin m_flag[k] = 0; m_en[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of both registers
        step("R1 flags", 1, 4'h0, 0, 0, 0, 0, 1, 0, 8'h00);
        step("R1 enables", 1, 4'h0, 0, 0, 0, 0, 1, 1, 8'h00);
        // R9, R10: enables written with reserved bits set read back 0x0F
        step("R10 en wr", 1, 4'h0, 0, 0, 0, 1, 0, 1, 8'hFF);
        step("R10 en rd", 1, 4'h0, 0, 0, 0, 0, 1, 1, 8'h00);
        // R2: compare A sets bit 1
        step("R2 cmpA", 1, 4'h2, 0, 0, 0, 0, 0, 0, 8'h00);
        rd_flag("R2 read");
        // R3: overflow ignored without the qualifier, taken with it
        step("R3 noqual", 1, 4'h1, 0, 0, 0, 0, 0, 0, 8'h00);
        rd_flag("R3 read0");
        step("R3 qual", 1, 4'h1, 1, 0, 0, 0, 0, 0, 8'h00);
        rd_flag("R3 read1");
        // R8: all pending, lowest wins; R6: ack of 0 clears only bit 0
        step("R2 cmpB cap", 1, 4'hC, 0, 0, 0, 0, 0, 0, 8'h00);
        step("R6 ack0", 1, 4'h0, 0, 1, 2'd0, 0, 1, 0, 8'h00);
        rd_flag("R6 read");
        // R5: write-one clears bit 2 only; R10 reserved writes ignored
        step("R5 w1c", 1, 4'h0, 0, 0, 0, 1, 0, 0, 8'h04);
        rd_flag("R5 read");
        step("R10 flag wr", 1, 4'h0, 0, 0, 0, 1, 0, 0, 8'hF0);
        rd_flag("R10 read");
        // R7: set beats write-one on bit 1, and beats ack on bit 3
        step("R7 set+w1c", 1, 4'h2, 0, 0, 0, 1, 0, 0, 8'h02);
        rd_flag("R7 read w1c");
        step("R7 set+ack", 1, 4'h8, 0, 1, 2'd3, 0, 0, 0, 8'h00);
        rd_flag("R7 read ack");
        // R4: global enable low masks everything
        step("R4 gie off", 0, 4'h0, 0, 0, 0, 0, 1, 0, 8'h00);
        // R9: disabling keeps the flags; re-enabling raises the request at once
        step("R9 dis", 1, 4'h0, 0, 0, 0, 1, 0, 1, 8'h00);
        rd_flag("R9 kept");
        step("R9 en", 1, 4'h0, 0, 0, 0, 1, 0, 1, 8'h08);
        rd_flag("R9 pending");
        // R11: no read strobe gives zero data
        step("R11 no rd", 1, 4'h0, 0, 0, 0, 0, 0, 0, 8'h00);
        // Random mix of all inputs
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R7 rand", lfsr[0] | lfsr[1], lfsr[5:2], lfsr[6],
                 lfsr[7] & lfsr[8], lfsr[10:9], lfsr[11] & lfsr[12],
                 lfsr[13], lfsr[14], {lfsr[3:0], lfsr[15:12]});
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule